// File: doc/BRIEF.md
# Dual-Path Serial RF Register Writer

This block gives a host a register-bus view of the small register files inside an RF die, reached over a three-wire serial link. There is one link for each RF path. Each path has a command slot on the bus. One bus write into that slot carries a complete packed word: an operation flag, an 8-bit RF register address and a 20-bit value. The block then sends the word out bit by bit on that path's serial clock, data and enable lines. The host does nothing else for the transfer.

A read works in two halves. First the flag and the address go out. Then the RF die drives the register contents back on the serial input line, and the block collects those 20 bits. It does not return them on the bus at once. It places them in a per-path shadow slot, and the host reads that slot after the transfer has ended. A status slot shows which paths are active. A command written to a path that is still sending is stalled with a wait signal until the path is free, so no command is lost. Both paths work independently and can run at the same time.

Top module: `rfser_writer`

## Requirements
- R1: After reset every enable, serial clock and serial data output is low, the status slot reads 0 and every shadow slot reads 0. The serial clock never toggles while its enable is low.
- R2: A bus write to command slot p (bus address p) on an idle path raises that path's enable on the next cycle. The enable then stays high for exactly 29*DIV system cycles. Each accepted command produces exactly one frame.
- R3: A frame carries 29 bits, most significant first. Command word bit 28 is the operation flag (1 = read, 0 = write), bits [27:20] are the RF address and bits [19:0] are the write value. In a read frame the 20 value positions go out as 0.
- R4: Serial data changes only on the falling edge of the serial clock. It stays stable for the whole high phase.
- R5: Each bit lasts DIV system cycles. The first DIV/2 cycles have the serial clock low and the last DIV/2 have it high, so a frame holds 29*DIV/2 high cycles.
- R6: In a read frame the block samples serial input on the rising edge of bits 9 to 28. The first sampled bit is value bit 19. At the end of the frame the 20-bit result is stored in shadow slot p (bus address NPATH+p) and is read back there, zero-extended.
- R7: A write frame leaves that path's shadow slot unchanged.
- R8: Reading the status slot (bus address 2*NPATH) returns one active bit per path in bits [NPATH-1:0], with all other bits 0.
- R9: A command write to a path that is still active holds bus_wait high. The write is held, not dropped, and is taken on the first cycle the path is idle.
- R10: The paths are independent. A command on one path can start while the other path is in the middle of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Bus write strobe, held until accepted |
| bus_rd | input | 1 | Bus read strobe; read data is valid in the same cycle |
| bus_addr | input | AW | Slot index: commands, then shadows, then status |
| bus_wdata | input | 29 | Packed command word |
| bus_rdata | output | 32 | Read data, zero while bus_rd is low |
| bus_wait | output | 1 | Write stalled because the target path is active |
| rf_sclk | output | NPATH | Per-path serial clock |
| rf_sdo | output | NPATH | Per-path serial data out |
| rf_sen | output | NPATH | Per-path frame enable |
| rf_sdi | input | NPATH | Per-path serial data returned by the RF die |

## Verification
The bench builds the block with two paths and DIV set to 4. At that divider a frame lasts 116 cycles, so many frames fit in one run: writes with all-zero, all-one and alternating bit patterns, reads with distinct return values, a command held off behind a running frame, and two paths running frames that overlap in time. A small divider also gives only two cycles per clock phase. That makes an off-by-one in the phase split, or in the cycle on which serial input is sampled, show up directly in the bit count and the returned value.

// File: rtl/rfser_pkg.sv
package rfser_pkg;
  localparam int RA_W    = 8;
  localparam int RD_W    = 20;
  localparam int FRAME_W = 1 + RA_W + RD_W;
  localparam int OUT_RD  = 1 + RA_W;

  // Frame image for a command word: reads drive zeros in the value field.
  function automatic logic [FRAME_W-1:0] frame_of(input logic [FRAME_W-1:0] w);
    if (w[FRAME_W-1]) return {1'b1, w[FRAME_W-2 -: RA_W], {RD_W{1'b0}}};
    return w;
  endfunction

  function automatic int cmd_slot(input int p);
    return p;
  endfunction

  function automatic int shadow_slot(input int np, input int p);
    return np + p;
  endfunction

  function automatic int status_slot(input int np);
    return 2 * np;
  endfunction
endpackage

// File: rtl/rfser_link.sv
module rfser_link
  import rfser_pkg::*;
#(
  parameter int DIV = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [FRAME_W-1:0] start_word,
  input  logic               sdi,
  output logic               sclk,
  output logic               sdo,
  output logic               sen,
  output logic               busy,
  output logic               frame_done,
  output logic               frame_read,
  output logic [RD_W-1:0]    shadow
);
  localparam int HALF = DIV / 2;
  localparam int CW   = (DIV > 2) ? $clog2(DIV) : 1;
  localparam int BW   = $clog2(FRAME_W + 1);

  logic               active;
  logic [CW-1:0]      div_cnt;
  logic [BW-1:0]      bit_cnt;
  logic [FRAME_W-1:0] shreg;
  logic               rd_q;
  logic [RD_W-1:0]    cap;
  logic [RD_W-1:0]    shadow_q;

  logic bit_end, last_bit, cap_en;

  assign bit_end  = active && (div_cnt == CW'(DIV - 1));
  assign last_bit = (bit_cnt == BW'(FRAME_W - 1));
  assign cap_en   = active && rd_q && (div_cnt == CW'(HALF)) && (bit_cnt >= BW'(OUT_RD));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= 1'b0;
      div_cnt <= '0;
      bit_cnt <= '0;
      shreg   <= '0;
      rd_q    <= 1'b0;
      cap     <= '0;
    end else if (start && !active) begin
      active  <= 1'b1;
      div_cnt <= '0;
      bit_cnt <= '0;
      shreg   <= frame_of(start_word);
      rd_q    <= start_word[FRAME_W-1];
      cap     <= '0;
    end else if (active) begin
      if (cap_en) cap <= {cap[RD_W-2:0], sdi};
      if (bit_end) begin
        div_cnt <= '0;
        shreg   <= {shreg[FRAME_W-2:0], 1'b0};
        bit_cnt <= bit_cnt + 1'b1;
        if (last_bit) active <= 1'b0;
      end else begin
        div_cnt <= div_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                          shadow_q <= '0;
    else if (bit_end && last_bit && rd_q) shadow_q <= cap;
  end

  assign sclk       = active && (div_cnt >= CW'(HALF));
  assign sdo        = active && shreg[FRAME_W-1];
  assign sen        = active;
  assign busy       = active;
  assign frame_done = bit_end && last_bit;
  assign frame_read = rd_q;
  assign shadow     = shadow_q;
endmodule

// File: rtl/rfser_bus.sv
module rfser_bus
  import rfser_pkg::*;
#(
  parameter int NPATH = 2,
  parameter int AW    = 3
) (
  input  logic                       bus_wr,
  input  logic                       bus_rd,
  input  logic [AW-1:0]              bus_addr,
  input  logic [NPATH-1:0]           busy,
  input  logic [NPATH-1:0][RD_W-1:0] shadow,
  output logic [NPATH-1:0]           start,
  output logic                       bus_wait,
  output logic [31:0]                bus_rdata
);
  logic [NPATH-1:0] hit, stall;

  for (genvar p = 0; p < NPATH; p++) begin : g_dec
    assign hit[p]   = bus_wr && (bus_addr == AW'(cmd_slot(p)));
    assign start[p] = hit[p] && !busy[p];
    assign stall[p] = hit[p] && busy[p];
  end

  assign bus_wait = |stall;

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      for (int p = 0; p < NPATH; p++)
        if (bus_addr == AW'(shadow_slot(NPATH, p))) bus_rdata = 32'(shadow[p]);
      if (bus_addr == AW'(status_slot(NPATH))) bus_rdata = 32'(busy);
    end
  end
endmodule

// File: rtl/rfser_writer.sv
module rfser_writer
  import rfser_pkg::*;
#(
  parameter int NPATH = 2,
  parameter int DIV   = 8,
  localparam int AW   = $clog2(2 * NPATH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [AW-1:0]      bus_addr,
  input  logic [FRAME_W-1:0] bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               bus_wait,
  output logic [NPATH-1:0]   rf_sclk,
  output logic [NPATH-1:0]   rf_sdo,
  output logic [NPATH-1:0]   rf_sen,
  input  logic [NPATH-1:0]   rf_sdi
);
  logic [NPATH-1:0]           link_start;
  logic [NPATH-1:0]           link_busy;
  logic [NPATH-1:0]           link_done;
  logic [NPATH-1:0]           link_read;
  logic [NPATH-1:0][RD_W-1:0] shadow;

  rfser_bus #(.NPATH(NPATH), .AW(AW)) u_bus (
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .busy     (link_busy),
    .shadow   (shadow),
    .start    (link_start),
    .bus_wait (bus_wait),
    .bus_rdata(bus_rdata)
  );

  for (genvar p = 0; p < NPATH; p++) begin : g_path
    rfser_link #(.DIV(DIV)) u_link (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (link_start[p]),
      .start_word(bus_wdata),
      .sdi       (rf_sdi[p]),
      .sclk      (rf_sclk[p]),
      .sdo       (rf_sdo[p]),
      .sen       (rf_sen[p]),
      .busy      (link_busy[p]),
      .frame_done(link_done[p]),
      .frame_read(link_read[p]),
      .shadow    (shadow[p])
    );
  end
endmodule

// File: rtl/rfser_writer_chk.sv
module rfser_writer_chk
  import rfser_pkg::*;
#(
  parameter int NPATH = 2,
  parameter int AW    = 3
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       bus_wr,
  input logic                       bus_rd,
  input logic [AW-1:0]              bus_addr,
  input logic [31:0]                bus_rdata,
  input logic                       bus_wait,
  input logic [NPATH-1:0]           rf_sclk,
  input logic [NPATH-1:0]           rf_sdo,
  input logic [NPATH-1:0]           rf_sen,
  input logic [NPATH-1:0]           link_done,
  input logic [NPATH-1:0]           link_read,
  input logic [NPATH-1:0][RD_W-1:0] shadow
);
  for (genvar p = 0; p < NPATH; p++) begin : g_chk
    assert_clk_gated_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !rf_sen[p] |-> !rf_sclk[p]);

    assert_start_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rf_sen[p]) |-> $past(bus_wr && !bus_wait && bus_addr == AW'(p)));

    assert_sdo_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_sclk[p] && $past(rf_sclk[p])) |-> $stable(rf_sdo[p]));

    assert_shadow_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(link_done[p] && link_read[p]) |=> $stable(shadow[p]));

    assert_wait_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wait && bus_addr == AW'(p)) |-> rf_sen[p]);
  end

  assert_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == AW'(2 * NPATH)) |-> bus_rdata == 32'(rf_sen));
endmodule

bind rfser_writer rfser_writer_chk #(.NPATH(NPATH), .AW(AW)) u_chk (.*);

// File: tb/sim_rfser_writer.sv
module sim_rfser_writer;
  localparam int NP  = 2;
  localparam int DIV = 4;
  localparam int AW  = 3;
  localparam int FLEN = 29 * DIV;

  logic clk = 0;
  logic rst_n = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [28:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic bus_wait;
  logic [NP-1:0] rf_sclk, rf_sdo, rf_sen, rf_sdi;

  int checks = 0, fails = 0;
  logic [28:0] expq [NP][$];
  logic [19:0] dev_ret [NP];

  always #2 clk = ~clk;

  rfser_writer #(.NPATH(NP), .DIV(DIV)) u0 (.*);

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor: a device model per path
  for (genvar p = 0; p < NP; p++) begin : g_dev
    logic ps_sen = 0, ps_clk = 0, ps_sdo = 0, moved = 0, rdf = 0, sdi_b = 0;
    int len = 0, hi = 0, nb = 0;
    logic [28:0] got = '0, ex;
    assign rf_sdi[p] = sdi_b;
    always @(negedge clk) begin
      if (rf_sen[p] && !ps_sen) begin
        len = 0; hi = 0; nb = 0; got = '0; moved = 0; rdf = 0;
      end
      if (rf_sen[p]) begin
        len++;
        if (rf_sclk[p]) hi++;
        if (rf_sclk[p] && ps_clk && rf_sdo[p] != ps_sdo) moved = 1;
        if (rf_sclk[p] && !ps_clk) begin
          got = {got[27:0], rf_sdo[p]};
          nb++;
          if (nb == 1) rdf = rf_sdo[p];
        end
        if (!rf_sclk[p] && ps_clk && rdf && nb >= 9 && nb <= 28)
          sdi_b = dev_ret[p][28 - nb];
      end
      if (!rf_sen[p] && ps_sen) begin
        sdi_b = 0;
        if (expq[p].size() == 0) begin
          check(0, "R2 unexpected frame", got, 0);
        end else begin
          ex = expq[p].pop_front();
          check(got == ex && nb == 29, "R3 frame bits", got, ex);
        end
        check(len == FLEN, "R2 enable length", len, FLEN);
        check(hi == FLEN / 2, "R5 clock high cycles", hi, FLEN / 2);
        check(!moved, "R4 data moved while clock high", moved, 0);
      end
      ps_sen = rf_sen[p]; ps_clk = rf_sclk[p]; ps_sdo = rf_sdo[p];
    end
  end

  // Driver: pushes the expected frame, then issues the write; returns stall cycles
  task automatic send(input int p, input bit rd, input logic [7:0] a,
                      input logic [19:0] d, output int waits);
    logic [28:0] w;
    w = {rd, a, d};
    expq[p].push_back(rd ? {1'b1, a, 20'h0} : w);
    waits = 0;
    @(negedge clk);
    bus_wr = 1; bus_addr = AW'(p); bus_wdata = w;
    #1;
    while (bus_wait) begin
      waits++;
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd_slot(input int s, output logic [31:0] v);
    @(negedge clk);
    bus_rd = 1; bus_addr = AW'(s);
    #1 v = bus_rdata;
    bus_rd = 0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (rf_sen != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic [31:0] v;
    int w;
    dev_ret[0] = 20'hA5C3E;
    dev_ret[1] = 20'h5_1E97;
    repeat (4) @(negedge clk);
    check(rf_sen == 0 && rf_sclk == 0 && rf_sdo == 0, "R1 idle lines", {rf_sen, rf_sclk, rf_sdo}, 0);
    rst_n = 1;
    rd_slot(4, v); check(v == 0, "R1 status after reset", v, 0);
    rd_slot(2, v); check(v == 0, "R1 shadow0 after reset", v, 0);
    rd_slot(3, v); check(v == 0, "R1 shadow1 after reset", v, 0);

    // R2/R3 write patterns, R8 status while active
    send(0, 0, 8'hFF, 20'hFFFFF, w);
    rd_slot(4, v); check(v == 32'h1, "R8 status path0 active", v, 1);
    wait_idle();
    rd_slot(4, v); check(v == 0, "R8 status idle", v, 0);
    send(0, 0, 8'h00, 20'h00000, w); wait_idle();
    send(1, 0, 8'hA5, 20'h5A5A5, w); wait_idle();

    // R6 read back through shadow
    send(0, 1, 8'h18, 20'hFFFFF, w); wait_idle();
    rd_slot(2, v); check(v == 32'(dev_ret[0]), "R6 shadow0 value", v, dev_ret[0]);
    send(1, 1, 8'h3C, 20'h0, w); wait_idle();
    rd_slot(3, v); check(v == 32'(dev_ret[1]), "R6 shadow1 value", v, dev_ret[1]);

    // R7 write leaves shadow alone
    dev_ret[1] = 20'h0;
    send(1, 0, 8'h12, 20'h34567, w); wait_idle();
    rd_slot(3, v); check(v == 32'h51E97, "R7 shadow1 after write", v, 32'h51E97);

    // R9 hold-off behind a running frame
    send(0, 0, 8'h01, 20'h13579, w);
    send(0, 0, 8'h02, 20'h2468A, w);
    check(w > FLEN / 2, "R9 second write stalled", w, FLEN);
    wait_idle();

    // R10 concurrent paths
    send(0, 0, 8'h55, 20'hAAAAA, w);
    send(1, 0, 8'hAA, 20'h55555, w);
    @(negedge clk);
    check(rf_sen == 2'b11, "R10 both paths active", rf_sen, 3);
    check(w == 0, "R10 no stall across paths", w, 0);
    wait_idle();

    check(expq[0].size() == 0 && expq[1].size() == 0, "R2 all frames seen",
          expq[0].size() + expq[1].size(), 0);
    report();
  end
endmodule